// File: doc/BRIEF.md
# SPI Frame Master with Programmable Frame Delays

This block is the transfer engine of a serial peripheral interface master. On each request it asserts an active-low chip select and shifts one frame of 4 to 16 bits out on the data output. At the same time it shifts the same number of bits in from the data input. The frame length, clock polarity, clock phase and bit order are chosen at run time. They are latched when the request is accepted, so a change made later does not disturb the frame in flight.

Each frame has three timed phases, all counted in system clock cycles:

- a lead delay from chip-select assertion to the first serial clock edge;
- a trail delay from the last serial clock edge to chip-select negation;
- a gap delay that keeps chip select high before the next frame may begin.

Between the lead and the trail, serial clock edges are spaced by a programmable half-period.

A one-cycle done pulse, an optional end-of-list pulse and a frame counter update are raised together at a fixed edge inside the frame. That edge depends on the clock phase. A request that arrives while the engine is busy is remembered and served as soon as the gap delay ends.

Top module: `spi_frame_master`

## Requirements
- R1: When idle, a start request is accepted at the next clock edge. In that edge `cs_n_o` goes low, `busy_o` goes high and `mosi_o` already shows the first data bit, before any serial clock edge.
- R2: The first serial clock edge comes exactly `csc_dly_i` cycles after chip select falls. Later edges follow every `half_per_i` cycles, and a frame of N bits has exactly 2N edges.
- R3: With `cpha_i`=0, `miso_i` is captured on odd-numbered edges (1, 3, …) and `mosi_o` changes on even-numbered edges. The data sent and received match the frame words.
- R4: With `cpha_i`=1, `mosi_o` advances on odd-numbered edges from edge 3 on and `miso_i` is captured on even-numbered edges. The data sent and received match the frame words.
- R5: With `lsb_first_i`=0, bit N-1 of `tx_data_i` is sent first and the first bit received becomes bit N-1 of `rx_data_o`. With `lsb_first_i`=1, bit 0 goes first and the first bit received becomes bit 0. The received word is right-aligned in `rx_data_o` and its upper bits are zero.
- R6: The serial clock rests at the `cpol_i` level before the first edge and after the last edge of a frame.
- R7: `cs_n_o` rises exactly `asc_dly_i` cycles after the last serial clock edge.
- R8: `busy_o` falls exactly `dt_dly_i` cycles after `cs_n_o` rises. A start request seen while busy is held. Its frame then begins with chip select falling `dt_dly_i`+1 cycles after the previous rise, with no further request.
- R9: `done_o` pulses for one cycle in the same cycle as edge 2N-1 when `cpha_i`=0, or edge 2N when `cpha_i`=1. In that same cycle `rx_count_o` increases by one, `rx_data_o` holds the new word, and `eol_o` pulses only if `eol_i` was high when the frame was accepted.
- R10: A delay or half-period value of 0 acts as 1. A frame size below 4 acts as 4 and one above 16 acts as 16.
- R11: After reset, `cs_n_o` is high, `sck_o`, `busy_o`, `done_o` and `eol_o` are low, and `rx_count_o` and `rx_data_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Frame request, held internally if busy |
| eol_i | input | 1 | Marks the requested frame as the last of a list |
| cpol_i | input | 1 | Serial clock idle level |
| cpha_i | input | 1 | Clock phase select |
| lsb_first_i | input | 1 | 1: least significant bit first |
| frame_bits_i | input | FB_W (5) | Frame length in bits, 4..16 |
| csc_dly_i | input | DLY_W (8) | Chip select to first edge, cycles |
| asc_dly_i | input | DLY_W (8) | Last edge to chip-select negation, cycles |
| dt_dly_i | input | DLY_W (8) | Minimum chip-select high time, cycles |
| half_per_i | input | DLY_W (8) | Serial clock half-period, cycles |
| tx_data_i | input | MAX_BITS (16) | Word to send, right-aligned |
| miso_i | input | 1 | Serial data in |
| sck_o | output | 1 | Serial clock |
| cs_n_o | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data out |
| busy_o | output | 1 | High from acceptance to end of gap delay |
| rx_data_o | output | MAX_BITS (16) | Last received word, right-aligned |
| done_o | output | 1 | Transfer-complete pulse |
| eol_o | output | 1 | End-of-list pulse |
| rx_count_o | output | RXC_W (8) | Frames received, wrapping |

## Verification
The hardest situation to reach is a request that arrives in the middle of a frame. It must survive the trail and gap phases and then start the next frame without a second request. The bench raises `start_i` for one cycle at a chosen cycle inside a running frame. It then follows that frame, stops driving requests, and requires chip select to fall exactly one cycle after `busy_o` drops. A second subtle point is the cycle where the last data capture, the done pulse and the counter step all coincide. The bench sweeps every combination of phase, polarity and bit order over several frame lengths and delays, so that this cycle lands on both edge parities.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LEAD,
      ST_XFER,
      ST_TRAIL,
      ST_GAP
   } fm_state_e;

   typedef struct packed {
      logic cpha;
      logic eol;
   } fm_mode_t;

endpackage

// File: rtl/spi_fm_timer.sv
module spi_fm_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          expired
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CW'(1);
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/spi_fm_shifter.sv
module spi_fm_shifter #(
   parameter int MAX_BITS = 16,
   parameter int FB_W     = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic                load_lsb,
   input  logic [FB_W-1:0]     load_nbits,
   input  logic [MAX_BITS-1:0] tx_word,
   input  logic                advance,
   input  logic                sample,
   input  logic                miso,
   output logic                mosi,
   output logic [MAX_BITS-1:0] rx_aligned
);

   logic                lsb_q;
   logic [FB_W-1:0]     nb_q;
   logic [MAX_BITS-1:0] tx_q;
   logic [MAX_BITS-1:0] rx_q;
   logic [MAX_BITS-1:0] rx_shifted;
   logic [FB_W-1:0]     pad_run;
   logic [FB_W-1:0]     pad_load;

   assign pad_run  = FB_W'(MAX_BITS) - nb_q;
   assign pad_load = FB_W'(MAX_BITS) - load_nbits;

   assign rx_shifted = lsb_q ? {miso, rx_q[MAX_BITS-1:1]}
                             : {rx_q[MAX_BITS-2:0], miso};
   assign rx_aligned = lsb_q ? (rx_shifted >> pad_run) : rx_shifted;
   assign mosi       = lsb_q ? tx_q[0] : tx_q[MAX_BITS-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lsb_q <= 1'b0;
         nb_q  <= FB_W'(MAX_BITS);
         tx_q  <= '0;
         rx_q  <= '0;
      end else if (load) begin
         lsb_q <= load_lsb;
         nb_q  <= load_nbits;
         tx_q  <= load_lsb ? tx_word : (tx_word << pad_load);
         rx_q  <= '0;
      end else begin
         if (advance) begin
            tx_q <= lsb_q ? (tx_q >> 1) : (tx_q << 1);
         end
         if (sample) begin
            rx_q <= rx_shifted;
         end
      end
   end

endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master #(
   parameter int MAX_BITS = 16,
   parameter int MIN_BITS = 4,
   parameter int DLY_W    = 8,
   parameter int RXC_W    = 8,
   parameter int FB_W     = $clog2(MAX_BITS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic                eol_i,
   input  logic                cpol_i,
   input  logic                cpha_i,
   input  logic                lsb_first_i,
   input  logic [FB_W-1:0]     frame_bits_i,
   input  logic [DLY_W-1:0]    csc_dly_i,
   input  logic [DLY_W-1:0]    asc_dly_i,
   input  logic [DLY_W-1:0]    dt_dly_i,
   input  logic [DLY_W-1:0]    half_per_i,
   input  logic [MAX_BITS-1:0] tx_data_i,
   input  logic                miso_i,
   output logic                sck_o,
   output logic                cs_n_o,
   output logic                mosi_o,
   output logic                busy_o,
   output logic [MAX_BITS-1:0] rx_data_o,
   output logic                done_o,
   output logic                eol_o,
   output logic [RXC_W-1:0]    rx_count_o
);
   import spi_fm_pkg::*;

   localparam int EI_W = $clog2(2 * MAX_BITS + 1);

   if (MIN_BITS < 2 || MIN_BITS > MAX_BITS) begin : g_bad_bits
      $error("spi_frame_master: MIN_BITS must lie in 2..MAX_BITS");
   end
   if (DLY_W < 1 || RXC_W < 1) begin : g_bad_width
      $error("spi_frame_master: DLY_W and RXC_W must be positive");
   end
   if (FB_W < $clog2(MAX_BITS + 1)) begin : g_bad_fbw
      $error("spi_frame_master: FB_W too narrow for MAX_BITS");
   end

   function automatic logic [DLY_W-1:0] minus_one(input logic [DLY_W-1:0] d);
      return (d == '0) ? '0 : d - DLY_W'(1);
   endfunction

   fm_state_e           state_q, state_d;
   fm_mode_t            mode_q;
   logic                pend_q;
   logic [FB_W-1:0]     nbits_q, nbits_in;
   logic [DLY_W-1:0]    half_q, asc_q, dt_q;
   logic [EI_W-1:0]     edge_q, edge_num, edge_total, flag_at;
   logic                sck_q, cs_n_q, done_q, eol_q;
   logic [RXC_W-1:0]    rxc_q;
   logic [MAX_BITS-1:0] rxd_q, rx_next;

   logic                accept, tmr_load, tmr_zero, do_edge;
   logic                edge_odd, sh_adv, sh_smp, flag_edge, last_edge;
   logic [DLY_W-1:0]    tmr_val;

   assign nbits_in = (frame_bits_i < FB_W'(MIN_BITS)) ? FB_W'(MIN_BITS) :
                     (frame_bits_i > FB_W'(MAX_BITS)) ? FB_W'(MAX_BITS) :
                     frame_bits_i;

   assign accept     = (state_q == ST_IDLE) && (start_i || pend_q);
   assign edge_num   = (state_q == ST_LEAD) ? EI_W'(1) : edge_q + EI_W'(1);
   assign edge_total = EI_W'({nbits_q, 1'b0});
   assign flag_at    = mode_q.cpha ? edge_total : edge_total - EI_W'(1);
   assign last_edge  = (edge_num == edge_total);
   assign edge_odd   = edge_num[0];

   assign sh_adv    = do_edge && (mode_q.cpha ? (edge_odd && edge_num != EI_W'(1))
                                              : !edge_odd);
   assign sh_smp    = do_edge && (mode_q.cpha ? !edge_odd : edge_odd);
   assign flag_edge = do_edge && (edge_num == flag_at);

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      do_edge  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (accept) begin
               state_d  = ST_LEAD;
               tmr_load = 1'b1;
               tmr_val  = minus_one(csc_dly_i);
            end
         end
         ST_LEAD: begin
            if (tmr_zero) begin
               do_edge  = 1'b1;
               state_d  = ST_XFER;
               tmr_load = 1'b1;
               tmr_val  = minus_one(half_q);
            end
         end
         ST_XFER: begin
            if (tmr_zero) begin
               do_edge  = 1'b1;
               tmr_load = 1'b1;
               if (last_edge) begin
                  state_d = ST_TRAIL;
                  tmr_val = minus_one(asc_q);
               end else begin
                  tmr_val = minus_one(half_q);
               end
            end
         end
         ST_TRAIL: begin
            if (tmr_zero) begin
               state_d  = ST_GAP;
               tmr_load = 1'b1;
               tmr_val  = minus_one(dt_q);
            end
         end
         ST_GAP: begin
            if (tmr_zero) begin
               state_d = ST_IDLE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   spi_fm_timer #(.CW(DLY_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_zero)
   );

   spi_fm_shifter #(.MAX_BITS(MAX_BITS), .FB_W(FB_W)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (accept),
      .load_lsb   (lsb_first_i),
      .load_nbits (nbits_in),
      .tx_word    (tx_data_i),
      .advance    (sh_adv),
      .sample     (sh_smp),
      .miso       (miso_i),
      .mosi       (mosi_o),
      .rx_aligned (rx_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         mode_q  <= '0;
         pend_q  <= 1'b0;
         nbits_q <= FB_W'(MAX_BITS);
         half_q  <= '0;
         asc_q   <= '0;
         dt_q    <= '0;
         edge_q  <= '0;
         sck_q   <= 1'b0;
         cs_n_q  <= 1'b1;
         done_q  <= 1'b0;
         eol_q   <= 1'b0;
         rxc_q   <= '0;
         rxd_q   <= '0;
      end else begin
         state_q <= state_d;
         pend_q  <= (pend_q | start_i) & ~accept;
         done_q  <= flag_edge;
         eol_q   <= flag_edge & mode_q.eol;
         if (state_q == ST_IDLE) begin
            sck_q <= cpol_i;
         end
         if (accept) begin
            mode_q.cpha <= cpha_i;
            mode_q.eol  <= eol_i;
            nbits_q     <= nbits_in;
            half_q      <= half_per_i;
            asc_q       <= asc_dly_i;
            dt_q        <= dt_dly_i;
            edge_q      <= '0;
            cs_n_q      <= 1'b0;
         end
         if (do_edge) begin
            sck_q  <= ~sck_q;
            edge_q <= edge_num;
         end
         if (flag_edge) begin
            rxc_q <= rxc_q + RXC_W'(1);
            rxd_q <= rx_next;
         end
         if (state_q == ST_TRAIL && tmr_zero) begin
            cs_n_q <= 1'b1;
         end
      end
   end

   assign sck_o      = sck_q;
   assign cs_n_o     = cs_n_q;
   assign busy_o     = (state_q != ST_IDLE);
   assign done_o     = done_q;
   assign eol_o      = eol_q;
   assign rx_count_o = rxc_q;
   assign rx_data_o  = rxd_q;

endmodule

// File: rtl/spi_fm_checker.sv
module spi_fm_checker #(
   parameter int RXC_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sck_o,
   input logic             cs_n_o,
   input logic             busy_o,
   input logic             done_o,
   input logic             eol_o,
   input logic [RXC_W-1:0] rx_count_o
);

   AST_CS_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n_o |-> busy_o); // R1

   AST_SCK_ONLY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !$stable(sck_o)) |-> !cs_n_o); // R2

   AST_SCK_REST_IN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && cs_n_o && $past(busy_o && cs_n_o)) |-> $stable(sck_o)); // R6

   AST_GAP_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n_o) |-> busy_o); // R8

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R9

   AST_EOL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      eol_o |-> done_o); // R9

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (rx_count_o == $past(rx_count_o) + RXC_W'(1))); // R9

   AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(rx_count_o)); // R9

endmodule

bind spi_frame_master spi_fm_checker #(.RXC_W(RXC_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sck_o      (sck_o),
   .cs_n_o     (cs_n_o),
   .busy_o     (busy_o),
   .done_o     (done_o),
   .eol_o      (eol_o),
   .rx_count_o (rx_count_o)
);

// File: tb/spi_frame_master_test.sv
`timescale 1ns/1ps
module spi_frame_master_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0, eol_i = 1'b0, cpol_i = 1'b0, cpha_i = 1'b0;
   logic        lsb_first_i = 1'b0, miso_i = 1'b0;
   logic [4:0]  frame_bits_i = 5'd8;
   logic [7:0]  csc_dly_i = 8'd1, asc_dly_i = 8'd1, dt_dly_i = 8'd1, half_per_i = 8'd1;
   logic [15:0] tx_data_i = '0;
   logic        sck_o, cs_n_o, mosi_o, busy_o, done_o, eol_o;
   logic [15:0] rx_data_o;
   logic [7:0]  rx_count_o;

   int errors = 0;
   int checks = 0;
   int exp_rxc = 0;

   always #10 clk = ~clk;

   spi_frame_master uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .eol_i(eol_i),
      .cpol_i(cpol_i), .cpha_i(cpha_i), .lsb_first_i(lsb_first_i),
      .frame_bits_i(frame_bits_i), .csc_dly_i(csc_dly_i), .asc_dly_i(asc_dly_i),
      .dt_dly_i(dt_dly_i), .half_per_i(half_per_i), .tx_data_i(tx_data_i),
      .miso_i(miso_i), .sck_o(sck_o), .cs_n_o(cs_n_o), .mosi_o(mosi_o),
      .busy_o(busy_o), .rx_data_o(rx_data_o), .done_o(done_o), .eol_o(eol_o),
      .rx_count_o(rx_count_o)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic run_frame(input bit pha, input bit pol, input bit lsb, input bit eo,
                            input int fb, input int csc, input int asc, input int dt,
                            input int half, input logic [15:0] tx, input logic [15:0] rxp,
                            input bit no_start, input int pulse_at);
      int nb, ec, ea, ed, eh, e, cyc, last, rise, ndone, k, fe;
      bit prev, chg, fin;
      logic [15:0] mask, cap;
      string rq;
      nb = (fb < 4) ? 4 : (fb > 16) ? 16 : fb;
      ec = (csc == 0) ? 1 : csc;
      ea = (asc == 0) ? 1 : asc;
      ed = (dt == 0) ? 1 : dt;
      eh = (half == 0) ? 1 : half;
      mask = 16'((32'd1 << nb) - 1);
      rq = pha ? "R4" : "R3";
      cpha_i = pha; cpol_i = pol; lsb_first_i = lsb; eol_i = eo;
      frame_bits_i = 5'(fb); csc_dly_i = 8'(csc); asc_dly_i = 8'(asc);
      dt_dly_i = 8'(dt); half_per_i = 8'(half); tx_data_i = tx;
      if (!no_start) start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(cs_n_o == 1'b0, "R1", "cs low after request", cs_n_o, 0);
      chk(busy_o == 1'b1, "R1", "busy after request", busy_o, 1);
      chk(mosi_o == (lsb ? tx[0] : tx[nb-1]), "R1", "first bit before clock",
          mosi_o, lsb ? tx[0] : tx[nb-1]);
      chk(sck_o == pol, "R6", "clock rest level at start", sck_o, pol);
      miso_i = lsb ? rxp[0] : rxp[nb-1];
      prev = sck_o; e = 0; cyc = 0; last = -1; rise = -1; ndone = 0; cap = '0; fin = 0;
      fe = pha ? 2*nb : 2*nb - 1;
      for (int g = 0; g < 5000 && !fin; g++) begin
         @(negedge clk);
         cyc++;
         if (cyc == pulse_at) start_i = 1'b1;
         else if (cyc == pulse_at + 1) start_i = 1'b0;
         chg = (sck_o != prev);
         if (chg) begin
            e++;
            prev = sck_o;
            last = cyc;
            chk(cyc == ec + (e-1)*eh, "R2", "edge timing", cyc, ec + (e-1)*eh);
            if ((pha && e % 2 == 0) || (!pha && e % 2 == 1)) begin
               k = pha ? e/2 - 1 : (e-1)/2;
               if (k < nb) cap[lsb ? k : nb-1-k] = mosi_o;
            end else begin
               k = pha ? (e+1)/2 - 1 : e/2;
               if (k < nb) miso_i = lsb ? rxp[k] : rxp[nb-1-k];
            end
         end
         if (done_o) begin
            ndone++;
            exp_rxc = (exp_rxc + 1) % 256;
            chk(chg && e == fe, "R9", "done edge index", e, fe);
            chk(eol_o == eo, "R9", "end-of-list pulse", eol_o, eo);
            chk(rx_count_o == 8'(exp_rxc), "R9", "frame count", rx_count_o, exp_rxc);
            chk(rx_data_o == (rxp & mask), rq, "received word R5", rx_data_o, rxp & mask);
         end
         if (cs_n_o && rise < 0) begin
            rise = cyc;
            chk(cyc == last + ea, "R7", "trail delay", cyc, last + ea);
         end
         if (!busy_o) begin
            chk(rise >= 0 && cyc == rise + ed, "R8", "gap delay", cyc, rise + ed);
            fin = 1;
         end
      end
      chk(fin, "R8", "frame finished", fin, 1);
      chk(e == 2*nb, "R2", "edge count", e, 2*nb);
      chk(ndone == 1, "R9", "done pulses per frame", ndone, 1);
      chk(cap == (tx & mask), rq, "sent word R5", cap, tx & mask);
      chk(sck_o == pol, "R6", "clock rest level at end", sck_o, pol);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: run did not end, actual 0 expected 1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int i;
      int sizes[4] = '{4, 5, 8, 16};
      repeat (3) @(negedge clk);
      chk(cs_n_o == 1'b1, "R11", "reset cs", cs_n_o, 1);
      chk(sck_o == 1'b0, "R11", "reset sck", sck_o, 0);
      chk(busy_o == 1'b0, "R11", "reset busy", busy_o, 0);
      chk(done_o == 1'b0 && eol_o == 1'b0, "R11", "reset flags", done_o, 0);
      chk(rx_count_o == 0, "R11", "reset count", rx_count_o, 0);
      chk(rx_data_o == 0, "R11", "reset data", rx_data_o, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      i = 0;
      for (int pha = 0; pha < 2; pha++)
         for (int pol = 0; pol < 2; pol++)
            for (int lsb = 0; lsb < 2; lsb++)
               for (int s = 0; s < 4; s++) begin
                  run_frame(pha[0], pol[0], lsb[0], i[0], sizes[s],
                            1 + i % 3, 1 + (i + 1) % 3, 1 + i % 2, 1 + (i / 2) % 3,
                            16'hA5C3 ^ 16'(i * 16'h1357), 16'h3C96 + 16'(i * 7),
                            1'b0, -10);
                  i++;
                  @(negedge clk);
               end
      // R10: zero delays act as one, short and long sizes clamp
      run_frame(1'b0, 1'b1, 1'b0, 1'b1, 2, 0, 0, 0, 0, 16'h000B, 16'h0006, 1'b0, -10);
      @(negedge clk);
      run_frame(1'b1, 1'b0, 1'b1, 1'b0, 25, 0, 2, 0, 1, 16'hF00D, 16'h8421, 1'b0, -10);
      @(negedge clk);
      // R8: request raised mid-frame is held and served after the gap
      run_frame(1'b0, 1'b0, 1'b0, 1'b0, 6, 2, 2, 3, 2, 16'h002D, 16'h0033, 1'b0, 7);
      run_frame(1'b1, 1'b1, 1'b0, 1'b1, 7, 1, 1, 2, 1, 16'h0055, 16'h006A, 1'b1, -10);
      repeat (3) @(negedge clk);
      chk(cs_n_o == 1'b1 && busy_o == 1'b0, "R8", "no extra frame without request",
          busy_o, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule